// File: doc/BRIEF.md
# Fetch-Execute Bus Cycle Controller

This block is the bus-facing half of a small processor. It alternates an instruction fetch phase with an execute phase. On every bus cycle it drives a fixed code on three control qualifiers:

- `bus_memio`: memory space versus I/O space.
- `bus_wr`: direction, write versus read.
- `bus_dc`: data transfer versus instruction fetch.

Alongside that code it drives a 32-bit address and a 32-bit outgoing data word. It takes a separate 32-bit incoming data word.

During a fetch it reads the word at the instruction pointer and returns it. The surrounding decoder classifies the fetched word in the same cycle. It presents an operation class, an operand address and a write value, and the controller latches all three at the end of the fetch. The execute phase that follows either runs one bus cycle (memory read, memory write, I/O read or I/O write) or, for operations that stay inside the processor, leaves the bus quiet for one cycle.

Two address-window decoders produce chip selects. They combine the address with the memory/I-O qualifier: one for a memory region and one for an I/O register region. A `run` input lets the sequencer stop at an instruction boundary and resume later.

Top module: `fxb_cycle_ctrl`

## Requirements
- R1: After reset the bus is quiet (`bus_active`=0) and `instr_valid`=0 and `rd_valid`=0. The first fetch after `run` rises uses address 0x00000000.
- R2: A fetch cycle drives (`bus_memio`,`bus_wr`,`bus_dc`) = (1,0,0) with the instruction pointer on `bus_addr`. The pointer grows by 4 after every fetch.
- R3: The word on `bus_rdata` during a fetch cycle appears on `instr_word`, with `instr_valid`=1, in the following cycle only.
- R4: The execute cycle comes right after the fetch and drives `op_addr` as latched at the fetch. The `op_kind` codes and their (`bus_memio`,`bus_wr`,`bus_dc`) values are:
  - 1: memory read, (1,0,1)
  - 2: memory write, (1,1,1)
  - 3: I/O read, (0,0,1)
  - 4: I/O write, (0,1,1)
- R5: For `op_kind` 0, 5, 6 or 7 the execute cycle makes no bus access: `bus_active`=0, and the qualifiers, `bus_addr`, `bus_wdata` and both selects are 0. The next fetch follows as for a bus operation.
- R6: `bus_wdata` carries the latched write value only in a write cycle and is 0 in every other cycle.
- R7: The word on `bus_rdata` during a read execute cycle appears on `rd_word`, with `rd_valid`=1, in the following cycle only.
- R8: The selects decode the address window during a bus cycle and are never both 1.
  - `cs_mem`=1 only during a bus cycle with `bus_memio`=1 and an address inside the memory window (default 0x00000000 to 0x00000FFF).
  - `cs_io`=1 only with `bus_memio`=0 and an address inside the I/O window (default 0x00000000 to 0x000000FF).
- R9: `run` is sampled while idle and at the end of every execute phase: 1 starts a fetch, 0 enters the idle state with a quiet bus. Two fetch cycles never follow one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Continue fetching at the next instruction boundary |
| op_kind | input | 3 | Operation class of the word being fetched |
| op_addr | input | 32 | Operand address of the word being fetched |
| op_wdata | input | 32 | Write value of the word being fetched |
| bus_rdata | input | 32 | Incoming data from the selected device |
| bus_active | output | 1 | A bus cycle is in progress this clock |
| bus_memio | output | 1 | 1 memory space, 0 I/O space |
| bus_wr | output | 1 | 1 processor to device, 0 device to processor |
| bus_dc | output | 1 | 1 execute data transfer, 0 instruction fetch |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Outgoing data |
| cs_mem | output | 1 | Memory window selected |
| cs_io | output | 1 | I/O window selected |
| instr_word | output | 32 | Last fetched instruction word |
| instr_valid | output | 1 | `instr_word` updated in the previous cycle |
| rd_word | output | 32 | Last execute read data |
| rd_valid | output | 1 | `rd_word` updated in the previous cycle |

## Verification
The hardest situations to reach from the ports depend on the fetched word itself. A read-after-write through a device and an access whose address falls outside both windows both need the right sequence of program words. Two further cases hinge on a single cycle of `run`: stopping exactly at an execute boundary, and resuming from idle.

The bench builds a program memory whose first words are fixed corner cases, followed by seeded random words. These corner-case words cover:
- a write then read of the same memory word, and of the same I/O register;
- out-of-window memory and I/O addresses;
- reserved class codes.

The random words mix all eight class codes with a small share of out-of-window addresses. The bench drops `run` at random instruction boundaries and compares every cycle's control code, address, outgoing data and selects against its own phase model.

// File: rtl/fxb_pkg.sv
package fxb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FETCH    = 2'd1,
        ST_EXEC_BUS = 2'd2,
        ST_EXEC_INT = 2'd3
    } phase_e;

    localparam logic [2:0] KIND_MEM_RD = 3'd1;
    localparam logic [2:0] KIND_MEM_WR = 3'd2;
    localparam logic [2:0] KIND_IO_RD  = 3'd3;
    localparam logic [2:0] KIND_IO_WR  = 3'd4;

    typedef struct packed {
        logic memio;
        logic wr;
        logic dc;
    } ctl_t;

    localparam ctl_t CTL_QUIET = '{memio: 1'b0, wr: 1'b0, dc: 1'b0};
    localparam ctl_t CTL_FETCH = '{memio: 1'b1, wr: 1'b0, dc: 1'b0};

    function automatic logic is_bus_kind(input logic [2:0] k);
        return (k >= KIND_MEM_RD) && (k <= KIND_IO_WR);
    endfunction

    function automatic ctl_t exec_ctl(input logic [2:0] k);
        ctl_t c;
        case (k)
            KIND_MEM_RD: c = '{memio: 1'b1, wr: 1'b0, dc: 1'b1};
            KIND_MEM_WR: c = '{memio: 1'b1, wr: 1'b1, dc: 1'b1};
            KIND_IO_RD:  c = '{memio: 1'b0, wr: 1'b0, dc: 1'b1};
            KIND_IO_WR:  c = '{memio: 1'b0, wr: 1'b1, dc: 1'b1};
            default:     c = CTL_QUIET;
        endcase
        return c;
    endfunction

    function automatic logic is_read_kind(input logic [2:0] k);
        return (k == KIND_MEM_RD) || (k == KIND_IO_RD);
    endfunction

endpackage

// File: rtl/fxb_sequencer.sv
module fxb_sequencer
    import fxb_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [2:0]      op_kind,
    input  logic [AW-1:0]   op_addr,
    input  logic [DW-1:0]   op_wdata,
    output phase_e          phase,
    output logic [AW-1:0]   ip,
    output logic [2:0]      lat_kind,
    output logic [AW-1:0]   lat_addr,
    output logic [DW-1:0]   lat_wdata
);

    localparam int IP_STEP = DW / 8;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= ST_IDLE;
            ip        <= '0;
            lat_kind  <= '0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else begin
            case (phase)
                ST_IDLE: begin
                    if (run) phase <= ST_FETCH;
                end
                ST_FETCH: begin
                    ip        <= ip + AW'(IP_STEP);
                    lat_kind  <= op_kind;
                    lat_addr  <= op_addr;
                    lat_wdata <= op_wdata;
                    phase     <= is_bus_kind(op_kind) ? ST_EXEC_BUS : ST_EXEC_INT;
                end
                default: begin
                    phase <= run ? ST_FETCH : ST_IDLE;
                end
            endcase
        end
    end

    // R9: a fetch is always followed by an execute phase
    a_r9_no_double_fetch: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_FETCH) |=> (phase == ST_EXEC_BUS || phase == ST_EXEC_INT));

    // R9: an execute phase with run low ends in idle
    a_r9_stop_at_boundary: assert property (@(posedge clk) disable iff (rst)
        ((phase == ST_EXEC_BUS || phase == ST_EXEC_INT) && !run) |=> (phase == ST_IDLE));

    // R2: the pointer moves one word per fetch
    a_r2_ip_step: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_FETCH) |=> (ip == $past(ip) + AW'(IP_STEP)));

    // R5: reserved and internal classes never reach the bus phase
    a_r5_internal_path: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_FETCH && !is_bus_kind(op_kind)) |=> (phase == ST_EXEC_INT));

endmodule

// File: rtl/fxb_bus_drive.sv
module fxb_bus_drive
    import fxb_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  phase_e          phase,
    input  logic [AW-1:0]   ip,
    input  logic [2:0]      lat_kind,
    input  logic [AW-1:0]   lat_addr,
    input  logic [DW-1:0]   lat_wdata,
    output logic            active,
    output ctl_t            ctl,
    output logic [AW-1:0]   addr,
    output logic [DW-1:0]   wdata
);

    ctl_t exec_code;

    always_comb begin
        exec_code = exec_ctl(lat_kind);
        active    = 1'b0;
        ctl       = CTL_QUIET;
        addr      = '0;
        wdata     = '0;
        case (phase)
            ST_FETCH: begin
                active = 1'b1;
                ctl    = CTL_FETCH;
                addr   = ip;
            end
            ST_EXEC_BUS: begin
                active = 1'b1;
                ctl    = exec_code;
                addr   = lat_addr;
                if (exec_code.wr) wdata = lat_wdata;
            end
            default: ;
        endcase
    end

    // R6: outgoing data is zero outside write cycles
    a_r6_wdata_quiet: assert property (@(posedge clk) disable iff (rst)
        !(active && ctl.wr) |-> (wdata == '0));

    // R5: no bus cycle means quiet qualifiers and address
    a_r5_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !active |-> (ctl == CTL_QUIET && addr == '0));

    // R4: every execute transfer carries the data qualifier
    a_r4_exec_is_data: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_EXEC_BUS) |-> (active && ctl.dc));

endmodule

// File: rtl/fxb_window_select.sv
module fxb_window_select #(
    parameter int              AW        = 32,
    parameter logic [AW-1:0]   BASE      = '0,
    parameter int              SPAN_LOG2 = 12,
    parameter bit              WANT_MEM  = 1'b1
) (
    input  logic            active,
    input  logic            memio,
    input  logic [AW-1:0]   addr,
    output logic            sel
);

    localparam logic [AW-1:0] HI_MASK = ~((AW'(1) << SPAN_LOG2) - AW'(1));

    logic space_ok;
    logic range_ok;

    always_comb begin
        space_ok = (memio == WANT_MEM);
        range_ok = ((addr & HI_MASK) == (BASE & HI_MASK));
        sel      = active && space_ok && range_ok;
    end

endmodule

// File: rtl/fxb_capture.sv
module fxb_capture
    import fxb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  phase_e          phase,
    input  logic [2:0]      lat_kind,
    input  logic [DW-1:0]   bus_rdata,
    output logic [DW-1:0]   instr_word,
    output logic            instr_valid,
    output logic [DW-1:0]   rd_word,
    output logic            rd_valid
);

    logic take_instr;
    logic take_read;

    always_comb begin
        take_instr = (phase == ST_FETCH);
        take_read  = (phase == ST_EXEC_BUS) && is_read_kind(lat_kind);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            instr_word  <= '0;
            instr_valid <= 1'b0;
            rd_word     <= '0;
            rd_valid    <= 1'b0;
        end else begin
            instr_valid <= take_instr;
            rd_valid    <= take_read;
            if (take_instr) instr_word <= bus_rdata;
            if (take_read)  rd_word    <= bus_rdata;
        end
    end

    // R3: an instruction strobe only follows a fetch cycle
    a_r3_strobe_after_fetch: assert property (@(posedge clk) disable iff (rst)
        instr_valid |-> ($past(phase) == ST_FETCH));

    // R7: instruction and read returns never coincide
    a_r7_one_return: assert property (@(posedge clk) disable iff (rst)
        !(instr_valid && rd_valid));

endmodule

// File: rtl/fxb_cycle_ctrl.sv
module fxb_cycle_ctrl
    import fxb_pkg::*;
#(
    parameter int              AW            = 32,
    parameter int              DW            = 32,
    parameter logic [AW-1:0]   MEM_BASE      = '0,
    parameter int              MEM_SPAN_LOG2 = 12,
    parameter logic [AW-1:0]   IO_BASE       = '0,
    parameter int              IO_SPAN_LOG2  = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [2:0]      op_kind,
    input  logic [AW-1:0]   op_addr,
    input  logic [DW-1:0]   op_wdata,
    input  logic [DW-1:0]   bus_rdata,
    output logic            bus_active,
    output logic            bus_memio,
    output logic            bus_wr,
    output logic            bus_dc,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata,
    output logic            cs_mem,
    output logic            cs_io,
    output logic [DW-1:0]   instr_word,
    output logic            instr_valid,
    output logic [DW-1:0]   rd_word,
    output logic            rd_valid
);

    localparam int N_WIN = 2;

    phase_e          phase;
    logic [AW-1:0]   ip;
    logic [2:0]      lat_kind;
    logic [AW-1:0]   lat_addr;
    logic [DW-1:0]   lat_wdata;
    ctl_t            ctl;
    logic [N_WIN-1:0] win_sel;

    fxb_sequencer #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .op_kind   (op_kind),
        .op_addr   (op_addr),
        .op_wdata  (op_wdata),
        .phase     (phase),
        .ip        (ip),
        .lat_kind  (lat_kind),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata)
    );

    fxb_bus_drive #(.AW(AW), .DW(DW)) u_drive (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .ip        (ip),
        .lat_kind  (lat_kind),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata),
        .active    (bus_active),
        .ctl       (ctl),
        .addr      (bus_addr),
        .wdata     (bus_wdata)
    );

    always_comb begin
        bus_memio = ctl.memio;
        bus_wr    = ctl.wr;
        bus_dc    = ctl.dc;
    end

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        fxb_window_select #(
            .AW        (AW),
            .BASE      ((g == 0) ? MEM_BASE : IO_BASE),
            .SPAN_LOG2 ((g == 0) ? MEM_SPAN_LOG2 : IO_SPAN_LOG2),
            .WANT_MEM  (g == 0)
        ) u_win (
            .active (bus_active),
            .memio  (bus_memio),
            .addr   (bus_addr),
            .sel    (win_sel[g])
        );
    end

    always_comb begin
        cs_mem = win_sel[0];
        cs_io  = win_sel[1];
    end

    fxb_capture #(.DW(DW)) u_cap (
        .clk         (clk),
        .rst         (rst),
        .phase       (phase),
        .lat_kind    (lat_kind),
        .bus_rdata   (bus_rdata),
        .instr_word  (instr_word),
        .instr_valid (instr_valid),
        .rd_word     (rd_word),
        .rd_valid    (rd_valid)
    );

    // R8: at most one device window answers
    a_r8_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cs_mem, cs_io}));

    // R8: selects need a live bus cycle
    a_r8_select_needs_cycle: assert property (@(posedge clk) disable iff (rst)
        !bus_active |-> (!cs_mem && !cs_io));

    // R2: the control-phase code is always a memory read
    a_r2_fetch_code: assert property (@(posedge clk) disable iff (rst)
        (bus_active && !bus_dc) |-> (bus_memio && !bus_wr));

    // R1: the cycle after reset is quiet
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!bus_active && !instr_valid && !rd_valid));

endmodule

// File: tb/sim_fxb_cycle_ctrl.sv
module sim_fxb_cycle_ctrl;

    localparam int FETCH_LIMIT = 230;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [2:0]  op_kind;
    logic [31:0] op_addr, op_wdata, bus_rdata;
    logic        bus_active, bus_memio, bus_wr, bus_dc, cs_mem, cs_io;
    logic [31:0] bus_addr, bus_wdata, instr_word, rd_word;
    logic        instr_valid, rd_valid;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    fxb_cycle_ctrl u0 (
        .clk(clk), .rst(rst), .run(run),
        .op_kind(op_kind), .op_addr(op_addr), .op_wdata(op_wdata),
        .bus_rdata(bus_rdata),
        .bus_active(bus_active), .bus_memio(bus_memio), .bus_wr(bus_wr), .bus_dc(bus_dc),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cs_mem(cs_mem), .cs_io(cs_io),
        .instr_word(instr_word), .instr_valid(instr_valid),
        .rd_word(rd_word), .rd_valid(rd_valid)
    );

    // program word layout: [31:29] class, [28] out-of-window flag, [7:0]/[3:0] operand index
    function automatic logic [31:0] f_addr(input logic [31:0] w);
        logic [2:0] k = w[31:29];
        if (k == 3'd1 || k == 3'd2)
            return (w[28] ? 32'h8000_0400 : 32'h0000_0400) + {22'b0, w[7:0], 2'b00};
        else if (k == 3'd3 || k == 3'd4)
            return (w[28] ? 32'h0000_0100 : 32'h0000_0000) + {28'b0, w[3:0]};
        return w;
    endfunction

    function automatic logic [31:0] f_wdata(input logic [31:0] w);
        return {8'hC3, w[23:0]};
    endfunction

    function automatic logic [31:0] mk(input logic [2:0] k, input bit far, input logic [7:0] idx);
        return {k, far, 20'h5A5A5, idx};
    endfunction

    // behavioural devices
    logic [31:0] env_mem [512];
    logic [31:0] env_io  [16];
    logic [31:0] ref_mem [512];
    logic [31:0] ref_io  [16];

    assign bus_rdata = cs_mem ? env_mem[bus_addr[10:2]] :
                       cs_io  ? env_io[bus_addr[3:0]]   : 32'hDEAD_BEEF;
    assign op_kind  = bus_rdata[31:29];
    assign op_addr  = f_addr(bus_rdata);
    assign op_wdata = f_wdata(bus_rdata);

    always @(posedge clk) begin
        if (cs_mem && bus_wr) env_mem[bus_addr[10:2]] <= bus_wdata;
        if (cs_io && bus_wr)  env_io[bus_addr[3:0]]   <= bus_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    typedef enum {M_IDLE, M_FETCH, M_EXB, M_EXI} mph_t;
    mph_t        mph;
    logic [31:0] m_ip, m_word;
    bit          exp_iv, exp_rv;
    logic [31:0] exp_iw, exp_rd;
    int          fetch_count, idle_after;
    bit          done = 0;

    task automatic quiet_check(input string req);
        chk(bus_active == 1'b0, req, "bus_active", {31'b0, bus_active}, 32'h0);
        chk({bus_memio, bus_wr, bus_dc} == 3'b000, req, "code", {29'b0, bus_memio, bus_wr, bus_dc}, 32'h0);
        chk(bus_addr == 32'h0, req, "addr", bus_addr, 32'h0);
        chk(bus_wdata == 32'h0, req, "wdata (R6)", bus_wdata, 32'h0);
        chk(!cs_mem && !cs_io, req, "selects (R8)", {30'b0, cs_mem, cs_io}, 32'h0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        // directed corner words first
        for (int i = 0; i < 256; i++) begin
            logic [31:0] w = $urandom;
            w[28] = (($urandom % 8) == 0);
            env_mem[i] = w;
        end
        env_mem[0]  = mk(3'd0, 0, 8'h00);  // internal op
        env_mem[1]  = mk(3'd2, 0, 8'h05);  // memory write
        env_mem[2]  = mk(3'd1, 0, 8'h05);  // read back
        env_mem[3]  = mk(3'd4, 0, 8'h03);  // io write
        env_mem[4]  = mk(3'd3, 0, 8'h03);  // io read back
        env_mem[5]  = mk(3'd1, 1, 8'h07);  // out-of-window memory read
        env_mem[6]  = mk(3'd4, 1, 8'h02);  // out-of-window io write
        env_mem[7]  = mk(3'd6, 0, 8'h00);  // reserved class
        env_mem[8]  = mk(3'd2, 1, 8'h05);  // out-of-window write must not land
        env_mem[9]  = mk(3'd1, 0, 8'h05);
        env_mem[10] = mk(3'd7, 1, 8'hFF);
        env_mem[11] = mk(3'd5, 0, 8'h11);
        for (int i = 256; i < 512; i++) env_mem[i] = $urandom;
        for (int i = 0; i < 16; i++) env_io[i] = $urandom;
        for (int i = 0; i < 512; i++) ref_mem[i] = env_mem[i];
        for (int i = 0; i < 16; i++) ref_io[i] = env_io[i];

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state while run is low
        quiet_check("R1");
        chk(!instr_valid && !rd_valid, "R1", "strobes", {30'b0, instr_valid, rd_valid}, 32'h0);
        run = 1'b1;   // leave idle at next edge
        mph = M_FETCH; m_ip = 32'h0; exp_iv = 0; exp_rv = 0; fetch_count = 0; idle_after = 0;

        for (int cyc = 0; cyc < 5000; cyc++) begin
            bit run_now;
            logic [2:0] k;
            logic [31:0] a;
            bit in_win, is_mem;
            @(negedge clk);
            chk(instr_valid == exp_iv, "R3", "instr_valid", {31'b0, instr_valid}, {31'b0, exp_iv});
            if (exp_iv) chk(instr_word == exp_iw, "R3", "instr_word", instr_word, exp_iw);
            chk(rd_valid == exp_rv, "R7", "rd_valid", {31'b0, rd_valid}, {31'b0, exp_rv});
            if (exp_rv) chk(rd_word == exp_rd, "R7", "rd_word", rd_word, exp_rd);
            exp_iv = 0; exp_rv = 0;

            run_now = (fetch_count < 12) ? 1'b1 :
                      (fetch_count >= FETCH_LIMIT) ? 1'b0 : (($urandom % 8) != 0);

            case (mph)
                M_IDLE: begin
                    quiet_check("R9");
                    run = run_now;
                    mph = run_now ? M_FETCH : M_IDLE;
                    if (fetch_count >= FETCH_LIMIT) idle_after++;
                end
                M_FETCH: begin
                    chk(bus_active && {bus_memio, bus_wr, bus_dc} == 3'b100, "R2", "fetch code",
                        {28'b0, bus_active, bus_memio, bus_wr, bus_dc}, 32'hC);
                    chk(bus_addr == m_ip, (fetch_count == 0) ? "R1" : "R2", "fetch addr", bus_addr, m_ip);
                    chk(bus_wdata == 32'h0, "R6", "fetch wdata", bus_wdata, 32'h0);
                    chk(cs_mem && !cs_io, "R8", "fetch selects", {30'b0, cs_mem, cs_io}, 32'h2);
                    m_word = ref_mem[m_ip[10:2]];
                    exp_iv = 1; exp_iw = m_word;
                    m_ip = m_ip + 32'd4;
                    fetch_count++;
                    k = m_word[31:29];
                    mph = (k >= 3'd1 && k <= 3'd4) ? M_EXB : M_EXI;
                end
                M_EXB: begin
                    logic [2:0] exp_code;
                    k = m_word[31:29];
                    a = f_addr(m_word);
                    is_mem = (k == 3'd1 || k == 3'd2);
                    in_win = is_mem ? (a < 32'h1000) : (a < 32'h100);
                    case (k)
                        3'd1: exp_code = 3'b101;
                        3'd2: exp_code = 3'b111;
                        3'd3: exp_code = 3'b001;
                        default: exp_code = 3'b011;
                    endcase
                    chk(bus_active && {bus_memio, bus_wr, bus_dc} == exp_code, "R4", "exec code",
                        {28'b0, bus_active, bus_memio, bus_wr, bus_dc}, {28'b1, exp_code});
                    chk(bus_addr == a, "R4", "exec addr", bus_addr, a);
                    chk(bus_wdata == (exp_code[1] ? f_wdata(m_word) : 32'h0), "R6", "exec wdata",
                        bus_wdata, exp_code[1] ? f_wdata(m_word) : 32'h0);
                    chk(cs_mem == (is_mem && in_win) && cs_io == (!is_mem && in_win), "R8", "exec selects",
                        {30'b0, cs_mem, cs_io}, {30'b0, is_mem && in_win, !is_mem && in_win});
                    if (!exp_code[1]) begin
                        exp_rv = 1;
                        exp_rd = !in_win ? 32'hDEAD_BEEF : is_mem ? ref_mem[a[10:2]] : ref_io[a[3:0]];
                    end else if (in_win) begin
                        if (is_mem) ref_mem[a[10:2]] = f_wdata(m_word);
                        else        ref_io[a[3:0]]   = f_wdata(m_word);
                    end
                    run = run_now;
                    mph = run_now ? M_FETCH : M_IDLE;
                end
                default: begin
                    quiet_check("R5");
                    run = run_now;
                    mph = run_now ? M_FETCH : M_IDLE;
                end
            endcase
            if (fetch_count >= FETCH_LIMIT && idle_after >= 2) break;
        end
        chk(fetch_count >= FETCH_LIMIT, "R9", "fetches reached", fetch_count, FETCH_LIMIT);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule